// File: doc/BRIEF.md
# Vector Fixed-Point Multiply Unit

This unit runs one multiply-class instruction at a time over a run of consecutive registers in a 128-entry, 32-bit register file that sits outside the unit. A single 32-bit instruction word selects the operand format (16x16 or 32x16 signed), a post-multiply arithmetic right shift of 0, 8 or 16 bits, optional rounding, an element count and one of three operations. The operations are an element-wise multiply, a dot product that collapses the run into one result, and a scale-and-add that multiplies each A element by the low half of register 1 and adds the matching B element.

The caller pulses `start` with a legal instruction while the unit is idle. The unit then holds `busy` for one cycle per element. It drives two register-file read addresses and takes the read data back in the same cycle. It issues at most one register-file write per cycle. Because every write lands at the clock edge that ends its element, the next element reads the updated file. `done` pulses for one cycle after the last element.

Top module: `vmul_unit`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `wr_en` are low until a legal `start` arrives.
- R2: The instruction fields are: [31:28] format, [27:24] count, [23] round, [22:21] operation, [20:14] A index, [13:7] destination index, [6:0] B index. In format 0, the product is the signed low 16 bits of A times the signed low 16 bits of B, truncated to 32 bits.
- R3: Formats 4, 5 and 6 multiply all 32 bits of A, taken as signed, by the signed low 16 bits of B.
- R4: Formats 1 and 5 shift the product arithmetically right by 8 bits. Formats 2 and 6 shift it right by 16 bits. Format 0 and format 4 do not shift.
- R5: When the round bit is set and the shift is nonzero, half of the lowest kept bit is added before the shift. When the shift is 0, the round bit changes nothing.
- R6: Operation 0 processes count+1 elements and writes each product to destination+i from A+i and B+i. Indices wrap modulo 128. `busy` is high for exactly count+1 cycles, and `done` pulses in the cycle after the last one.
- R7: Operation 1 sums the count+1 shifted products modulo 2^32 and writes that sum once, to the destination register, in the last busy cycle.
- R8: Operation 2 writes (A+i times the signed low half of register 1, shifted) plus B+i to destination+i. Register 1 is read fresh for every element.
- R9: A write whose destination index is 0 is dropped: `wr_en` stays low for it, and register 0 keeps its value.
- R10: A start carrying format 3, format 7, any format with bit 31 set, or operation 3 is ignored: `busy` stays low and nothing is written.
- R11: A `start` pulse that arrives while `busy` is high is ignored, and the running instruction completes unchanged.
- R12: Elements run in order, and each one sees the writes of the elements before it, so overlapping source and destination runs behave sequentially.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled when idle |
| instr | input | 32 | Instruction word |
| busy | output | 1 | High during each element cycle |
| done | output | 1 | One-cycle pulse after the last element |
| rd_a_addr | output | 7 | Register-file read index for operand A |
| rd_a_data | input | 32 | Data at `rd_a_addr`, same cycle |
| rd_b_addr | output | 7 | Register-file read index for operand B |
| rd_b_data | input | 32 | Data at `rd_b_addr`, same cycle |
| scale_lo | input | 16 | Low half of register 1, same cycle |
| wr_en | output | 1 | Register-file write strobe |
| wr_addr | output | 7 | Register-file write index |
| wr_data | output | 32 | Register-file write data |

## Verification
The hardest case to reach is a run in which the unit reads registers it has just written. This happens when the destination run overlaps a source run, when it rewrites register 1 during a scale-and-add, or when it wraps past index 127 into the discarded register 0. The stimulus aims such runs at those places on purpose. The bench's expected values come from a shadow copy of the register file that it updates element by element, so any read of stale data shows up as a data mismatch on the write port.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = 16;
  localparam int RIDX_W = 7;
  localparam int CNT_W  = 4;
  localparam int PROD_W = DATA_W + HALF_W;
  localparam int NSHIFT = 3;
  localparam int SHIFT_STEP = 8;

  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_DOT  = 2'd1,
    OP_AXPY = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    SH_0  = 2'd0,
    SH_8  = 2'd1,
    SH_16 = 2'd2
  } shift_e;

  typedef struct packed {
    logic              wide;
    shift_e            shift;
    logic              rnd;
    op_e               op;
    logic [CNT_W-1:0]  cnt;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rb;
  } cmd_t;
endpackage

// File: rtl/vmul_decode.sv
module vmul_decode
  import vmul_pkg::*;
(
  input  logic [DATA_W-1:0] instr,
  output cmd_t              cmd,
  output logic              cmd_ok
);
  logic [3:0] fmt;
  logic [1:0] opf;
  logic       fmt_ok;
  logic       op_ok;

  always_comb begin
    fmt        = instr[31:28];
    opf        = instr[22:21];
    fmt_ok     = (fmt[3] == 1'b0) && (fmt[1:0] != 2'b11);
    op_ok      = (opf != 2'b11);
    cmd_ok     = fmt_ok && op_ok;
    cmd.wide   = fmt[2];
    cmd.shift  = shift_e'(fmt[1:0]);
    cmd.rnd    = instr[23];
    cmd.op     = op_e'(opf);
    cmd.cnt    = instr[27:24];
    cmd.ra     = instr[20:14];
    cmd.rd     = instr[13:7];
    cmd.rb     = instr[6:0];
  end
endmodule

// File: rtl/vmul_lane.sv
module vmul_lane
  import vmul_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = HALF_W,
  parameter int NS = NSHIFT,
  parameter int STEP = SHIFT_STEP,
  localparam int PW = DW + HW
)(
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [HW-1:0] scale_in,
  input  logic          wide,
  input  shift_e        shift,
  input  logic          rnd,
  input  logic          axpy,
  output logic [DW-1:0] term
);
  logic signed [PW-1:0] xa;
  logic signed [PW-1:0] ys;
  logic signed [PW-1:0] prod;
  logic        [HW-1:0] mult_y;
  logic signed [PW-1:0] shifted [NS];
  logic signed [PW-1:0] picked;

  always_comb begin
    mult_y = axpy ? scale_in : b_in[HW-1:0];
    if (wide) begin
      xa = {{(PW-DW){a_in[DW-1]}}, a_in};
    end else begin
      xa = {{(PW-HW){a_in[HW-1]}}, a_in[HW-1:0]};
    end
    ys   = {{(PW-HW){mult_y[HW-1]}}, mult_y};
    prod = xa * ys;
  end

  for (genvar g = 0; g < NS; g++) begin : g_shift
    localparam int SH = g * STEP;
    if (SH == 0) begin : g_none
      assign shifted[g] = prod;
    end else begin : g_rnd
      logic signed [PW-1:0] biased;
      assign biased     = prod + (rnd ? (PW'(1) <<< (SH - 1)) : PW'(0));
      assign shifted[g] = biased >>> SH;
    end
  end

  always_comb begin
    case (shift)
      SH_8:    picked = shifted[1];
      SH_16:   picked = shifted[2];
      default: picked = shifted[0];
    endcase
    term = picked[DW-1:0] + (axpy ? b_in : '0);
  end
endmodule

// File: rtl/vmul_seq.sv
module vmul_seq
  import vmul_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = RIDX_W,
  parameter int CW = CNT_W
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  cmd_t          cmd,
  input  logic          cmd_ok,
  input  logic [DW-1:0] term,
  output logic          busy,
  output logic          done,
  output logic          wide,
  output shift_e        shift,
  output logic          rnd,
  output op_e           op,
  output logic [AW-1:0] a_idx,
  output logic [AW-1:0] b_idx,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          busy_q, busy_n;
  logic          done_q, done_n;
  logic [CW-1:0] elem_q, elem_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [AW-1:0] a_q, a_n, b_q, b_n, d_q, d_n;
  logic [DW-1:0] acc_q, acc_n;
  logic          wide_q, wide_n, rnd_q, rnd_n;
  shift_e        shift_q, shift_n;
  op_e           op_q, op_n;

  logic          accept;
  logic          last;
  logic          is_dot;
  logic          run_en;
  logic [DW-1:0] sum;
  logic          wr_fire;

  always_comb begin
    accept  = start && !busy_q && cmd_ok;
    last    = busy_q && (elem_q == cnt_q);
    is_dot  = (op_q == OP_DOT);
    sum     = acc_q + term;
    wr_fire = busy_q && (!is_dot || last);
    run_en  = accept || busy_q;
  end

  always_comb begin
    busy_n  = busy_q;
    done_n  = 1'b0;
    elem_n  = elem_q;
    cnt_n   = cnt_q;
    a_n     = a_q;
    b_n     = b_q;
    d_n     = d_q;
    acc_n   = acc_q;
    wide_n  = wide_q;
    rnd_n   = rnd_q;
    shift_n = shift_q;
    op_n    = op_q;
    if (accept) begin
      busy_n  = 1'b1;
      elem_n  = '0;
      cnt_n   = cmd.cnt;
      a_n     = cmd.ra;
      b_n     = cmd.rb;
      d_n     = cmd.rd;
      acc_n   = '0;
      wide_n  = cmd.wide;
      rnd_n   = cmd.rnd;
      shift_n = cmd.shift;
      op_n    = cmd.op;
    end else if (busy_q) begin
      elem_n = elem_q + 1'b1;
      a_n    = a_q + 1'b1;
      b_n    = b_q + 1'b1;
      if (!is_dot) begin
        d_n = d_q + 1'b1;
      end
      acc_n = sum;
      if (last) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q  <= '0;
      cnt_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      d_q     <= '0;
      acc_q   <= '0;
      wide_q  <= 1'b0;
      rnd_q   <= 1'b0;
      shift_q <= SH_0;
      op_q    <= OP_MUL;
    end else if (run_en) begin
      elem_q  <= elem_n;
      cnt_q   <= cnt_n;
      a_q     <= a_n;
      b_q     <= b_n;
      d_q     <= d_n;
      acc_q   <= acc_n;
      wide_q  <= wide_n;
      rnd_q   <= rnd_n;
      shift_q <= shift_n;
      op_q    <= op_n;
    end
  end

  always_comb begin
    busy    = busy_q;
    done    = done_q;
    wide    = wide_q;
    shift   = shift_q;
    rnd     = rnd_q;
    op      = op_q;
    a_idx   = a_q;
    b_idx   = b_q;
    wr_addr = d_q;
    wr_data = is_dot ? sum : term;
    wr_en   = wr_fire && (d_q != '0);
  end

  // R9: the zero register never receives a write
  assert_r0_discard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr != '0));

  // R7: a dot product writes only in its final element cycle
  assert_dot_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && is_dot && (elem_q != cnt_q)) |-> !wr_en);

  // R6: done follows the final busy cycle
  assert_done_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));

  // R6: destination steps by one per element for element-wise operations
  assert_dest_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !is_dot) |-> (d_q == $past(d_q) + 7'd1));

  // R11: a run in progress keeps its operation and count
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (elem_q != cnt_q)) |=> (busy_q && $stable(op_q) && $stable(cnt_q)));
endmodule

// File: rtl/vmul_unit.sv
module vmul_unit
  import vmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] instr,
  output logic              busy,
  output logic              done,
  output logic [RIDX_W-1:0] rd_a_addr,
  input  logic [DATA_W-1:0] rd_a_data,
  output logic [RIDX_W-1:0] rd_b_addr,
  input  logic [DATA_W-1:0] rd_b_data,
  input  logic [HALF_W-1:0] scale_lo,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic        rst_meta_q;
  logic        rst_sync_q;
  cmd_t        cmd;
  logic        cmd_ok;
  logic        wide;
  shift_e      shift;
  logic        rnd;
  op_e         op;
  logic [DATA_W-1:0] term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  vmul_decode u_decode (
    .instr  (instr),
    .cmd    (cmd),
    .cmd_ok (cmd_ok)
  );

  vmul_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .start   (start),
    .cmd     (cmd),
    .cmd_ok  (cmd_ok),
    .term    (term),
    .busy    (busy),
    .done    (done),
    .wide    (wide),
    .shift   (shift),
    .rnd     (rnd),
    .op      (op),
    .a_idx   (rd_a_addr),
    .b_idx   (rd_b_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  vmul_lane u_lane (
    .a_in     (rd_a_data),
    .b_in     (rd_b_data),
    .scale_in (scale_lo),
    .wide     (wide),
    .shift    (shift),
    .rnd      (rnd),
    .axpy     (op == OP_AXPY),
    .term     (term)
  );

  // R10: an illegal encoding offered while idle does not start a run
  assert_illegal_ignored_R10: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (start && !busy && !cmd_ok) |=> !busy);

  // R1: no write strobe outside a run
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !busy |-> !wr_en);
endmodule

// File: tb/vmul_unit_tb.sv
module vmul_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] instr;
  logic        busy, done;
  logic [6:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en;
  logic [15:0] scale_lo;

  logic [31:0] rf     [128];
  logic [31:0] shadow [128];

  typedef struct { logic [6:0] addr; logic [31:0] data; } wr_t;
  wr_t   exp_q[$];
  string cur_tag;
  int    checks;
  int    fails;
  int    cycles;

  assign rd_a_data = rf[rd_a_addr];
  assign rd_b_data = rf[rd_b_addr];
  assign scale_lo  = rf[1][15:0];

  vmul_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .busy(busy), .done(done),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .scale_lo(scale_lo),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (wr_en) rf[wr_addr] <= wr_data;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every observed write
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, cur_tag, "unexpected write", {25'd0, wr_addr}, 32'd0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        check(wr_addr == e.addr, cur_tag, "write index", {25'd0, wr_addr}, {25'd0, e.addr});
        check(wr_data == e.data, cur_tag, "write data", wr_data, e.data);
      end
    end
  end

  function automatic logic [31:0] mk(input logic [3:0] fmt, input logic [3:0] cnt,
      input logic rnd, input logic [1:0] op, input logic [6:0] ra,
      input logic [6:0] rd, input logic [6:0] rb);
    return {fmt, cnt, rnd, op, ra, rd, rb};
  endfunction

  function automatic logic [31:0] model_term(input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] s, input logic [3:0] fmt, input logic rnd, input logic axpy);
    longint x, y, p;
    int sh;
    logic [31:0] r;
    x  = fmt[2] ? longint'($signed(a)) : longint'($signed(a[15:0]));
    y  = axpy ? longint'($signed(s[15:0])) : longint'($signed(b[15:0]));
    p  = x * y;
    sh = 8 * int'(fmt[1:0]);
    if (rnd && sh > 0) p = p + (longint'(1) <<< (sh - 1));
    p = p >>> sh;
    r = p[31:0];
    if (axpy) r = r + b;
    return r;
  endfunction

  // driver: predicts every write into the scoreboard, then launches
  task automatic run(input logic [31:0] ins, input string tag,
                     input bit poke, input logic [31:0] poke_ins);
    logic [3:0] fmt;
    logic [1:0] op;
    int n;
    int nbusy;
    logic [31:0] acc;
    logic [6:0] ra, rb, rd;
    fmt = ins[31:28];
    op  = ins[22:21];
    n   = int'(ins[27:24]) + 1;
    ra  = ins[20:14];
    rd  = ins[13:7];
    rb  = ins[6:0];
    acc = 32'd0;
    cur_tag = tag;
    for (int i = 0; i < n; i++) begin
      logic [31:0] t;
      t = model_term(shadow[ra], shadow[rb], shadow[1], fmt, ins[23], op == 2'd2);
      if (op == 2'd1) begin
        acc = acc + t;
        if (i == n - 1 && rd != 7'd0) begin
          exp_q.push_back('{rd, acc});
          shadow[rd] = acc;
        end
      end else begin
        if (rd != 7'd0) begin
          exp_q.push_back('{rd, t});
          shadow[rd] = t;
        end
        rd = rd + 7'd1;
      end
      ra = ra + 7'd1;
      rb = rb + 7'd1;
    end
    @(posedge clk); #2;
    start = 1'b1;
    instr = ins;
    @(posedge clk); #2;
    start = 1'b0;
    nbusy = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (busy) nbusy++;
      if (poke && k == 1) begin
        #1;
        start = 1'b1;
        instr = poke_ins;
        @(posedge clk); #2;
        start = 1'b0;
        instr = ins;
      end
      if (done) break;
    end
    check(done == 1'b1, tag, "done pulse seen", {31'd0, done}, 32'd1);
    check(nbusy == n, tag, "busy cycles", nbusy, n);
    check(exp_q.size() == 0, tag, "writes outstanding", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic try_illegal(input logic [31:0] ins);
    @(posedge clk); #2;
    start = 1'b1;
    instr = ins;
    @(posedge clk); #2;
    start = 1'b0;
    cur_tag = "R10";
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(busy == 1'b0, "R10", "busy after illegal start", {31'd0, busy}, 32'd0);
    end
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        check(1'b0, "watchdog", "run timed out", cycles, 50000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    checks = 0;
    fails  = 0;
    cur_tag = "R1";
    start = 1'b0;
    instr = 32'd0;
    rst_n = 1'b0;
    for (int i = 0; i < 128; i++) begin
      logic [31:0] v;
      v = (i * 32'h9E3779B1) ^ (i << 13) ^ 32'h5A5A0F0F;
      rf[i]     = (i == 0) ? 32'd0 : v;
      shadow[i] = rf[i];
    end
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", {31'd0, busy}, 32'd0);
    check(wr_en == 1'b0, "R1", "wr_en in reset", {31'd0, wr_en}, 32'd0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", {31'd0, busy}, 32'd0);
    check(done == 1'b0, "R1", "done after reset", {31'd0, done}, 32'd0);

    // R2: 16x16, no shift, element-wise
    run(mk(4'd0, 4'd3, 1'b0, 2'd0, 7'd10, 7'd40, 7'd20), "R2", 1'b0, 32'd0);
    // R3: 32x16, no shift
    run(mk(4'd4, 4'd2, 1'b0, 2'd0, 7'd12, 7'd44, 7'd22), "R3", 1'b0, 32'd0);
    // R4: shifts of 8 and 16 in both widths
    run(mk(4'd1, 4'd2, 1'b0, 2'd0, 7'd14, 7'd48, 7'd24), "R4", 1'b0, 32'd0);
    run(mk(4'd6, 4'd2, 1'b0, 2'd0, 7'd15, 7'd52, 7'd25), "R4", 1'b0, 32'd0);
    // R5: rounding with shift, and no effect at shift 0
    run(mk(4'd5, 4'd3, 1'b1, 2'd0, 7'd16, 7'd56, 7'd26), "R5", 1'b0, 32'd0);
    run(mk(4'd2, 4'd3, 1'b1, 2'd0, 7'd17, 7'd60, 7'd27), "R5", 1'b0, 32'd0);
    run(mk(4'd0, 4'd1, 1'b1, 2'd0, 7'd18, 7'd64, 7'd28), "R5", 1'b0, 32'd0);
    check(rf[64] == model_term(rf[18], rf[28], 32'd0, 4'd0, 1'b0, 1'b0), "R5",
          "round ignored at shift 0", rf[64], model_term(rf[18], rf[28], 32'd0, 4'd0, 1'b0, 1'b0));
    // R6: longest run
    run(mk(4'd4, 4'd15, 1'b0, 2'd0, 7'd70, 7'd100, 7'd30), "R6", 1'b0, 32'd0);
    // R6 + R9: destination wraps through register 0
    run(mk(4'd0, 4'd3, 1'b0, 2'd0, 7'd120, 7'd126, 7'd5), "R9", 1'b0, 32'd0);
    check(rf[0] == 32'd0, "R9", "register 0 untouched", rf[0], 32'd0);
    // R9: single element aimed at register 0
    run(mk(4'd1, 4'd0, 1'b0, 2'd0, 7'd33, 7'd0, 7'd34), "R9", 1'b0, 32'd0);
    check(rf[0] == 32'd0, "R9", "register 0 untouched", rf[0], 32'd0);
    // R7: dot products
    run(mk(4'd0, 4'd7, 1'b0, 2'd1, 7'd40, 7'd90, 7'd48), "R7", 1'b0, 32'd0);
    run(mk(4'd5, 4'd4, 1'b1, 2'd1, 7'd100, 7'd91, 7'd56), "R7", 1'b0, 32'd0);
    // R8: scale-and-add, then one that rewrites register 1 mid-run
    run(mk(4'd1, 4'd3, 1'b1, 2'd2, 7'd80, 7'd110, 7'd84), "R8", 1'b0, 32'd0);
    run(mk(4'd4, 4'd2, 1'b0, 2'd2, 7'd2, 7'd0, 7'd9), "R8", 1'b0, 32'd0);
    // R10: illegal encodings
    try_illegal(mk(4'd3, 4'd2, 1'b0, 2'd0, 7'd10, 7'd20, 7'd30));
    try_illegal(mk(4'd8, 4'd2, 1'b0, 2'd0, 7'd10, 7'd20, 7'd30));
    try_illegal(mk(4'd0, 4'd2, 1'b0, 2'd3, 7'd10, 7'd20, 7'd30));
    check(rf[20] == shadow[20], "R10", "no write after illegal", rf[20], shadow[20]);
    // R11: start during a run is ignored
    run(mk(4'd2, 4'd5, 1'b1, 2'd0, 7'd60, 7'd112, 7'd66),
        "R11", 1'b1, mk(4'd0, 4'd1, 1'b0, 2'd0, 7'd3, 7'd4, 7'd5));
    // R12: overlapping runs see earlier results
    run(mk(4'd0, 4'd4, 1'b0, 2'd0, 7'd50, 7'd51, 7'd70), "R12", 1'b0, 32'd0);
    run(mk(4'd1, 4'd3, 1'b1, 2'd2, 7'd95, 7'd96, 7'd96), "R12", 1'b0, 32'd0);

    for (int i = 0; i < 128; i++) begin
      if (rf[i] != shadow[i]) check(1'b0, "R12", "final register state", rf[i], shadow[i]);
    end
    checks++;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule